// File: doc/BRIEF.md
# Misaligned Access Split Sequencer

This block sits between address generation and a data cache port. It takes load and store requests of 1, 2, 4 or 8 bytes at any byte address. It classifies each request and turns it into one or two whole-line cache accesses. A request that stays inside one 64-byte line costs a single cache access, whether it is aligned or not. A request that runs past the end of its line is cut into a low fragment and a high fragment. When the second line lies in the same 4 kB page, the high fragment reuses the request's physical frame with the next line index. When it lies in the next page, the block first asks an external translator for the frame of the next virtual page. It then sends the high fragment to line 0 of that frame.

For loads, each line returned by the cache is shifted so that the requested bytes fall at result byte 0. The bytes from the high fragment are shifted up past the low-fragment bytes and the two are combined. The result is zero-extended to 64 bits. For stores, the write data and byte enables are shifted up to the line offset. They are spread over the two fragments, and the low fragment is written first. The two fragments of a split access form no atomic unit and take no lock. On a page crossing, translation finishes before any cache access, so a translation fault ends the request with an error and nothing is written. The block handles one request at a time.

Top module: `misalign_split_seq`

## Requirements
- R1: Each response carries three flags. `rsp_misaligned` is set when the address is not a multiple of the size in bytes. `rsp_line_cross` is set when the line offset (address bits 5:0) plus the size exceeds 64. `rsp_page_cross` is set when the access crosses a line and the line index (address bits 11:6) is 63.
- R2: An access that does not cross a line makes exactly one cache access, at line `{req_pfn, vaddr[11:6]}`, and no translation request.
- R3: An access that crosses a line but not a page makes two cache accesses and no translation request. The second access goes to the same frame with the line index plus one.
- R4: An access that crosses a page raises one translation request for virtual page `vaddr[31:12] + 1`, before any cache access. If there is no fault, the second cache access goes to line index 0 of the returned frame.
- R5: A load returns byte i of the access (little-endian, address + i) in `rsp_data` bits `[8i+7:8i]`. Bytes at and above the access size are zero.
- R6: A store drives `cache_req_be` bit b and `cache_req_wdata` byte b for each line byte b that it writes. Write-data byte i lands at the line byte of address + i. The low fragment is issued first, and `cache_req_write` is 1. A store responds with `rsp_data` equal to zero.
- R7: A translation fault ends the request with `rsp_error` = 1 and `rsp_data` = 0, and no cache access is made.
- R8: `req_ready` is low from the cycle after a request is accepted until its response has been taken.
- R9: Once `rsp_valid` is raised, it and `rsp_data` hold steady until `rsp_ready` is seen. The same holds for a cache request and its line address and enables until `cache_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Log2 of the access size in bytes (0..3) |
| req_vaddr | input | 32 | Virtual byte address |
| req_pfn | input | 20 | Physical frame of the page holding the first byte |
| req_wdata | input | 64 | Store data, little-endian, byte 0 at the address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 64 | Load result, zero-extended; zero for stores and errors |
| rsp_error | output | 1 | Translation of the second page failed |
| rsp_misaligned | output | 1 | Address not a multiple of the size |
| rsp_line_cross | output | 1 | Access crossed a 64-byte line |
| rsp_page_cross | output | 1 | Access crossed a 4 kB page |
| xlat_req_valid | output | 1 | Translation of the next page requested |
| xlat_req_vpn | output | 20 | Virtual page to translate |
| xlat_rsp_valid | input | 1 | Translation result present |
| xlat_rsp_pfn | input | 20 | Translated physical frame |
| xlat_rsp_fault | input | 1 | Translation failed |
| cache_req_valid | output | 1 | Cache access present |
| cache_req_ready | input | 1 | Cache takes the access |
| cache_req_write | output | 1 | 1 = write fragment, 0 = read |
| cache_req_line | output | 26 | Physical line address (frame and line index) |
| cache_req_be | output | 64 | Byte enables within the line |
| cache_req_wdata | output | 512 | Line-positioned write data |
| cache_rsp_valid | input | 1 | Cache access completed |
| cache_rsp_rdata | input | 512 | Line read data, byte b at bits 8b+7:8b |

## Verification
The assertions assume three things about the neighbours. The cache returns exactly one `cache_rsp_valid` for each access it accepted, and never one unasked. The translator raises `xlat_rsp_valid` only while `xlat_req_valid` is high, and for one cycle. `req_size` never exceeds 3. The bench models both neighbours in the same way. The cache model answers one cycle after each handshake, and its ready toggles every cycle so that stalls are exercised. The translator model answers one cycle after a fresh request and then stays quiet until the next one. Stimulus sweeps every offset of a mid-page line and of the last line of two pages at all four sizes for loads and stores. The next page after one of those last lines faults.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_XLAT  = 3'd1,
    SEQ_ISSUE = 3'd2,
    SEQ_WAIT  = 3'd3,
    SEQ_RESP  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/msq_classify.sv
// Decides misalignment and line/page crossing and derives byte masks.
module msq_classify #(
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int DATA_BYTES = 8,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int PGOFF_W = $clog2(PAGE_BYTES),
  localparam int CNT_W   = $clog2(DATA_BYTES) + 1,
  localparam int SZ_W    = $clog2(CNT_W)
) (
  input  logic [PGOFF_W-1:0]    addr_low,
  input  logic [SZ_W-1:0]       size,
  output logic                  misaligned,
  output logic                  line_cross,
  output logic                  page_cross,
  output logic [DATA_BYTES-1:0] size_mask,
  output logic [DATA_BYTES-1:0] lo_mask,
  output logic [CNT_W-1:0]      lo_bytes
);
  logic [CNT_W-1:0]        nbytes;
  logic [OFF_W-1:0]        off;
  logic [OFF_W:0]          end_pos;
  logic [2*DATA_BYTES-1:0] size_sh;
  logic [2*DATA_BYTES-1:0] lo_sh;

  always_comb begin
    nbytes     = CNT_W'(1) << size;
    off        = addr_low[OFF_W-1:0];
    end_pos    = {1'b0, off} + (OFF_W+1)'(nbytes);
    misaligned = |(off & OFF_W'(nbytes - CNT_W'(1)));
    line_cross = end_pos > (OFF_W+1)'(LINE_BYTES);
    page_cross = line_cross && (&addr_low[PGOFF_W-1:OFF_W]);
    lo_bytes   = line_cross ? CNT_W'((OFF_W+1)'(LINE_BYTES) - {1'b0, off}) : nbytes;
    size_sh    = {{DATA_BYTES{1'b0}}, {DATA_BYTES{1'b1}}} << nbytes;
    lo_sh      = {{DATA_BYTES{1'b0}}, {DATA_BYTES{1'b1}}} << lo_bytes;
    size_mask  = ~size_sh[DATA_BYTES-1:0];
    lo_mask    = ~lo_sh[DATA_BYTES-1:0] & size_mask;
  end
endmodule

// File: rtl/msq_store_align.sv
// Moves store data and enables from byte 0 up to the line offset,
// over a two-line window; each half is one fragment.
module msq_store_align #(
  parameter int LINE_BYTES = 64,
  parameter int DATA_BYTES = 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int DATA_W = DATA_BYTES * 8
) (
  input  logic [OFF_W-1:0]                  off,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [DATA_BYTES-1:0]             byte_mask,
  output logic [1:0][LINE_W-1:0]            frag_data,
  output logic [1:0][LINE_BYTES-1:0]        frag_be
);
  logic [DATA_W-1:0]       wdata_m;
  logic [2*LINE_W-1:0]     win_d;
  logic [2*LINE_BYTES-1:0] win_be;

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_mask
    assign wdata_m[b*8 +: 8] = wdata[b*8 +: 8] & {8{byte_mask[b]}};
  end

  always_comb begin
    win_d  = {{(2*LINE_W-DATA_W){1'b0}}, wdata_m} << {off, 3'b000};
    win_be = {{(2*LINE_BYTES-DATA_BYTES){1'b0}}, byte_mask} << off;
  end

  for (genvar f = 0; f < 2; f++) begin : g_frag
    assign frag_data[f] = win_d[f*LINE_W +: LINE_W];
    assign frag_be[f]   = win_be[f*LINE_BYTES +: LINE_BYTES];
  end
endmodule

// File: rtl/msq_load_merge.sv
// Brings the requested bytes of a returned line down to byte 0 (low part),
// and shifts the head of the next line above them (high part).
module msq_load_merge #(
  parameter int LINE_BYTES = 64,
  parameter int DATA_BYTES = 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int DATA_W = DATA_BYTES * 8,
  localparam int CNT_W  = $clog2(DATA_BYTES) + 1
) (
  input  logic [LINE_W-1:0]     line,
  input  logic [OFF_W-1:0]      off,
  input  logic [CNT_W-1:0]      lo_bytes,
  input  logic [DATA_BYTES-1:0] lo_mask,
  input  logic [DATA_BYTES-1:0] size_mask,
  output logic [DATA_W-1:0]     lo_part,
  output logic [DATA_W-1:0]     hi_part
);
  logic [LINE_W-1:0] down;
  logic [DATA_W-1:0] up;
  logic [DATA_W-1:0] lo_bits;
  logic [DATA_W-1:0] sz_bits;

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_bits
    assign lo_bits[b*8 +: 8] = {8{lo_mask[b]}};
    assign sz_bits[b*8 +: 8] = {8{size_mask[b]}};
  end

  always_comb begin
    down    = line >> {off, 3'b000};
    up      = line[DATA_W-1:0] << {lo_bytes, 3'b000};
    lo_part = down[DATA_W-1:0] & lo_bits;
    hi_part = up & sz_bits & ~lo_bits;
  end
endmodule

// File: rtl/misalign_split_seq.sv
module misalign_split_seq #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int DATA_BYTES = 8,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int PGOFF_W = $clog2(PAGE_BYTES),
  localparam int LIDX_W  = PGOFF_W - OFF_W,
  localparam int VPN_W   = VA_W - PGOFF_W,
  localparam int PFN_W   = PA_W - PGOFF_W,
  localparam int LA_W    = PA_W - OFF_W,
  localparam int LINE_W  = LINE_BYTES * 8,
  localparam int DATA_W  = DATA_BYTES * 8,
  localparam int CNT_W   = $clog2(DATA_BYTES) + 1,
  localparam int SZ_W    = $clog2(CNT_W)
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_store,
  input  logic [SZ_W-1:0]       req_size,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [PFN_W-1:0]      req_pfn,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_data,
  output logic                  rsp_error,
  output logic                  rsp_misaligned,
  output logic                  rsp_line_cross,
  output logic                  rsp_page_cross,
  output logic                  xlat_req_valid,
  output logic [VPN_W-1:0]      xlat_req_vpn,
  input  logic                  xlat_rsp_valid,
  input  logic [PFN_W-1:0]      xlat_rsp_pfn,
  input  logic                  xlat_rsp_fault,
  output logic                  cache_req_valid,
  input  logic                  cache_req_ready,
  output logic                  cache_req_write,
  output logic [LA_W-1:0]       cache_req_line,
  output logic [LINE_BYTES-1:0] cache_req_be,
  output logic [LINE_W-1:0]     cache_req_wdata,
  input  logic                  cache_rsp_valid,
  input  logic [LINE_W-1:0]     cache_rsp_rdata
);
  import msq_pkg::*;

  // classification of the incoming request
  logic                  in_mis, in_lc, in_pc;
  logic [DATA_BYTES-1:0] in_size_mask, in_lo_mask;
  logic [CNT_W-1:0]      in_lo_bytes;

  msq_classify #(
    .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES), .DATA_BYTES(DATA_BYTES)
  ) classify_i (
    .addr_low  (req_vaddr[PGOFF_W-1:0]),
    .size      (req_size),
    .misaligned(in_mis),
    .line_cross(in_lc),
    .page_cross(in_pc),
    .size_mask (in_size_mask),
    .lo_mask   (in_lo_mask),
    .lo_bytes  (in_lo_bytes)
  );

  // state
  seq_state_e            st_q, st_d;
  logic                  frag_q, frag_d;
  logic                  err_q, err_d;
  logic [PFN_W-1:0]      pfn1_q, pfn1_d;
  logic [DATA_W-1:0]     data_q, data_d;
  logic                  store_q, mis_q, lc_q, pc_q;
  logic [DATA_BYTES-1:0] size_mask_q, lo_mask_q;
  logic [CNT_W-1:0]      lo_bytes_q;
  logic [VA_W-1:0]       vaddr_q;
  logic [PFN_W-1:0]      pfn0_q;
  logic [DATA_W-1:0]     wdata_q;
  logic                  accept;

  logic [OFF_W-1:0]  off_q;
  logic [LIDX_W-1:0] lidx_q;
  logic [VPN_W-1:0]  vpn_q;

  assign off_q  = vaddr_q[OFF_W-1:0];
  assign lidx_q = vaddr_q[PGOFF_W-1:OFF_W];
  assign vpn_q  = vaddr_q[VA_W-1:PGOFF_W];

  // datapath
  logic [1:0][LINE_W-1:0]     st_frag_data;
  logic [1:0][LINE_BYTES-1:0] st_frag_be;
  logic [DATA_W-1:0]          ld_lo, ld_hi;

  msq_store_align #(
    .LINE_BYTES(LINE_BYTES), .DATA_BYTES(DATA_BYTES)
  ) store_align_i (
    .off      (off_q),
    .wdata    (wdata_q),
    .byte_mask(size_mask_q),
    .frag_data(st_frag_data),
    .frag_be  (st_frag_be)
  );

  msq_load_merge #(
    .LINE_BYTES(LINE_BYTES), .DATA_BYTES(DATA_BYTES)
  ) load_merge_i (
    .line     (cache_rsp_rdata),
    .off      (off_q),
    .lo_bytes (lo_bytes_q),
    .lo_mask  (lo_mask_q),
    .size_mask(size_mask_q),
    .lo_part  (ld_lo),
    .hi_part  (ld_hi)
  );

  // outputs
  assign req_ready       = (st_q == SEQ_IDLE);
  assign accept          = req_valid && req_ready;
  assign rsp_valid       = (st_q == SEQ_RESP);
  assign rsp_data        = data_q;
  assign rsp_error       = err_q;
  assign rsp_misaligned  = mis_q;
  assign rsp_line_cross  = lc_q;
  assign rsp_page_cross  = pc_q;
  assign xlat_req_valid  = (st_q == SEQ_XLAT);
  assign xlat_req_vpn    = vpn_q + VPN_W'(1);
  assign cache_req_valid = (st_q == SEQ_ISSUE);
  assign cache_req_write = store_q;
  assign cache_req_be    = st_frag_be[frag_q];
  assign cache_req_wdata = st_frag_data[frag_q];

  always_comb begin
    if (!frag_q)
      cache_req_line = {pfn0_q, lidx_q};
    else if (pc_q)
      cache_req_line = {pfn1_q, {LIDX_W{1'b0}}};
    else
      cache_req_line = {pfn0_q, lidx_q + LIDX_W'(1)};
  end

  // next state
  always_comb begin
    st_d   = st_q;
    frag_d = frag_q;
    err_d  = err_q;
    pfn1_d = pfn1_q;
    data_d = data_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (req_valid) begin
          st_d   = in_pc ? SEQ_XLAT : SEQ_ISSUE;
          frag_d = 1'b0;
          err_d  = 1'b0;
          data_d = '0;
        end
      end
      SEQ_XLAT: begin
        if (xlat_rsp_valid) begin
          if (xlat_rsp_fault) begin
            err_d = 1'b1;
            st_d  = SEQ_RESP;
          end else begin
            pfn1_d = xlat_rsp_pfn;
            st_d   = SEQ_ISSUE;
          end
        end
      end
      SEQ_ISSUE: begin
        if (cache_req_ready) st_d = SEQ_WAIT;
      end
      SEQ_WAIT: begin
        if (cache_rsp_valid) begin
          if (!frag_q) begin
            if (!store_q) data_d = ld_lo;
            if (lc_q) begin
              frag_d = 1'b1;
              st_d   = SEQ_ISSUE;
            end else begin
              st_d = SEQ_RESP;
            end
          end else begin
            if (!store_q) data_d = data_q | ld_hi;
            st_d = SEQ_RESP;
          end
        end
      end
      SEQ_RESP: begin
        if (rsp_ready) st_d = SEQ_IDLE;
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SEQ_IDLE;
      frag_q      <= 1'b0;
      err_q       <= 1'b0;
      pfn1_q      <= '0;
      data_q      <= '0;
      store_q     <= 1'b0;
      mis_q       <= 1'b0;
      lc_q        <= 1'b0;
      pc_q        <= 1'b0;
      size_mask_q <= '0;
      lo_mask_q   <= '0;
      lo_bytes_q  <= '0;
      vaddr_q     <= '0;
      pfn0_q      <= '0;
      wdata_q     <= '0;
    end else begin
      st_q   <= st_d;
      frag_q <= frag_d;
      err_q  <= err_d;
      pfn1_q <= pfn1_d;
      data_q <= data_d;
      if (accept) begin
        store_q     <= req_store;
        mis_q       <= in_mis;
        lc_q        <= in_lc;
        pc_q        <= in_pc;
        size_mask_q <= in_size_mask;
        lo_mask_q   <= in_lo_mask;
        lo_bytes_q  <= in_lo_bytes;
        vaddr_q     <= req_vaddr;
        pfn0_q      <= req_pfn;
        wdata_q     <= req_store ? req_wdata : '0;
      end
    end
  end

  // assertions
  assert_single_access_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (cache_req_valid && !lc_q) |-> !frag_q);

  assert_next_line_same_frame_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (cache_req_valid && frag_q && !pc_q) |-> (cache_req_line[LA_W-1:LIDX_W] == pfn0_q));

  assert_xlat_only_on_page_cross_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    xlat_req_valid |-> pc_q);

  assert_page_second_line0_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (cache_req_valid && frag_q && pc_q) |-> (cache_req_line[LIDX_W-1:0] == '0));

  assert_no_access_after_fault_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    cache_req_valid |-> !err_q);

  assert_busy_no_accept_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid || cache_req_valid || xlat_req_valid) |-> !req_ready);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_error)));

  assert_cache_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (cache_req_valid && !cache_req_ready) |=>
      (cache_req_valid && $stable(cache_req_line) && $stable(cache_req_be)));

  assert_store_be_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (cache_req_valid && cache_req_write) |-> ($countones(cache_req_be) != 0));
endmodule

// File: tb/misalign_split_seq_tb_top.sv
module misalign_split_seq_tb_top;
  localparam logic [19:0] FAULT_VPN = 20'h00777;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  always #10 clk = ~clk;

  logic         req_valid = 1'b0, req_store = 1'b0;
  logic [1:0]   req_size = '0;
  logic [31:0]  req_vaddr = '0;
  logic [19:0]  req_pfn = '0;
  logic [63:0]  req_wdata = '0;
  logic         rsp_ready = 1'b0;
  logic         req_ready, rsp_valid, rsp_error, rsp_misaligned, rsp_line_cross, rsp_page_cross;
  logic [63:0]  rsp_data;
  logic         xlat_req_valid;
  logic [19:0]  xlat_req_vpn;
  logic         xlat_rsp_valid = 1'b0, xlat_rsp_fault = 1'b0;
  logic [19:0]  xlat_rsp_pfn = '0;
  logic         cache_req_valid, cache_req_write;
  logic         cache_req_ready = 1'b0;
  logic [25:0]  cache_req_line;
  logic [63:0]  cache_req_be;
  logic [511:0] cache_req_wdata;
  logic         cache_rsp_valid = 1'b0;
  logic [511:0] cache_rsp_rdata = '0;

  misalign_split_seq dut_i (
    .clk(clk), .rst_ni(rst_ni),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_size(req_size), .req_vaddr(req_vaddr), .req_pfn(req_pfn), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_error(rsp_error),
    .rsp_misaligned(rsp_misaligned), .rsp_line_cross(rsp_line_cross),
    .rsp_page_cross(rsp_page_cross),
    .xlat_req_valid(xlat_req_valid), .xlat_req_vpn(xlat_req_vpn),
    .xlat_rsp_valid(xlat_rsp_valid), .xlat_rsp_pfn(xlat_rsp_pfn),
    .xlat_rsp_fault(xlat_rsp_fault),
    .cache_req_valid(cache_req_valid), .cache_req_ready(cache_req_ready),
    .cache_req_write(cache_req_write), .cache_req_line(cache_req_line),
    .cache_req_be(cache_req_be), .cache_req_wdata(cache_req_wdata),
    .cache_rsp_valid(cache_rsp_valid), .cache_rsp_rdata(cache_rsp_rdata)
  );

  function automatic logic [19:0] xlate(input logic [19:0] vpn);
    return vpn ^ 20'h3C5A1;
  endfunction

  function automatic logic [31:0] phys(input logic [31:0] va);
    return {xlate(va[31:12]), va[11:0]};
  endfunction

  function automatic logic [7:0] mem_byte(input logic [31:0] pa);
    return pa[7:0] ^ pa[15:8] ^ {pa[21:16], 2'b11};
  endfunction

  // neighbour models and access log
  logic         clr_log = 1'b0;
  int           acc_cnt = 0, xl_cnt = 0;
  logic [19:0]  xl_vpn = '0;
  logic [25:0]  log_line [2];
  logic         log_we   [2];
  logic [63:0]  log_be   [2];
  logic [511:0] log_wd   [2];

  always @(negedge clk) cache_req_ready <= ~cache_req_ready;

  always @(posedge clk) begin
    cache_rsp_valid <= cache_req_valid && cache_req_ready;
    for (int b = 0; b < 64; b++)
      cache_rsp_rdata[b*8 +: 8] <= mem_byte({cache_req_line, 6'(b)});
    xlat_rsp_valid <= xlat_req_valid && !xlat_rsp_valid;
    xlat_rsp_pfn   <= xlate(xlat_req_vpn);
    xlat_rsp_fault <= (xlat_req_vpn == FAULT_VPN);
    if (clr_log) begin
      acc_cnt <= 0;
      xl_cnt  <= 0;
    end else begin
      if (cache_req_valid && cache_req_ready) begin
        if (acc_cnt < 2) begin
          log_line[acc_cnt] <= cache_req_line;
          log_we[acc_cnt]   <= cache_req_write;
          log_be[acc_cnt]   <= cache_req_be;
          log_wd[acc_cnt]   <= cache_req_wdata;
        end
        acc_cnt <= acc_cnt + 1;
      end
      if (xlat_req_valid && !xlat_rsp_valid) begin
        xl_cnt <= xl_cnt + 1;
        xl_vpn <= xlat_req_vpn;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_access(input bit st, input int sz, input logic [31:0] va);
    int n;
    bit mis, lc, pc, flt;
    logic [25:0]  line0, line1;
    logic [63:0]  exp_ld, got;
    logic [63:0]  wd;
    logic [63:0]  exp_be [2];
    logic [511:0] exp_wd [2];
    logic [511:0] bm;
    n   = 1 << sz;
    mis = (va % n) != 0;
    lc  = (int'(va[5:0]) + n) > 64;
    pc  = lc && (va[11:6] == 6'h3F);
    flt = pc && ((va[31:12] + 20'd1) == FAULT_VPN);
    wd  = {va ^ 32'hA5C3_0F1E, ~va} ^ {8{8'(sz)}};
    line0  = phys(va)[31:6];
    line1  = phys(va + 32'(n - 1))[31:6];
    exp_ld = '0;
    exp_be[0] = '0; exp_be[1] = '0; exp_wd[0] = '0; exp_wd[1] = '0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] p;
      int f;
      p = phys(va + 32'(i));
      f = (p[31:6] == line0) ? 0 : 1;
      exp_ld[i*8 +: 8] = mem_byte(p);
      exp_be[f][p[5:0]] = 1'b1;
      exp_wd[f][int'(p[5:0])*8 +: 8] = wd[i*8 +: 8];
    end
    @(negedge clk);
    clr_log   = 1'b1;
    @(negedge clk);
    clr_log   = 1'b0;
    req_valid = 1'b1; req_store = st; req_size = 2'(sz);
    req_vaddr = va; req_pfn = xlate(va[31:12]); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8 ready low while busy", 512'(req_ready), 512'(0));
    while (!rsp_valid) @(negedge clk);
    got = rsp_data;
    @(negedge clk);
    check(rsp_valid && rsp_data == got, "R9 response held", 512'(rsp_data), 512'(got));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check({rsp_misaligned, rsp_line_cross, rsp_page_cross} == {mis, lc, pc},
          "R1 flags", 512'({rsp_misaligned, rsp_line_cross, rsp_page_cross}),
          512'({mis, lc, pc}));
    if (flt) begin
      check(got_err(), "R7 error flag", 512'(rsp_error), 512'(1));
      check(got == 0 && acc_cnt == 0, "R7 no cache access, zero data",
            512'(acc_cnt), 512'(0));
    end else begin
      check(!rsp_error, "R7 no error", 512'(rsp_error), 512'(0));
      check(acc_cnt == (lc ? 2 : 1), lc ? "R3 two accesses" : "R2 one access",
            512'(acc_cnt), 512'(lc ? 2 : 1));
      check(log_line[0] == line0, "R2 first line", 512'(log_line[0]), 512'(line0));
      if (lc)
        check(log_line[1] == line1, pc ? "R4 second line in new frame" :
              "R3 second line same frame", 512'(log_line[1]), 512'(line1));
      if (st) begin
        for (int f = 0; f < (lc ? 2 : 1); f++) begin
          bm = '0;
          for (int b = 0; b < 64; b++) bm[b*8 +: 8] = {8{exp_be[f][b]}};
          check(log_we[f] && log_be[f] == exp_be[f], "R6 write enables",
                512'(log_be[f]), 512'(exp_be[f]));
          check((log_wd[f] & bm) == exp_wd[f], "R6 write data", log_wd[f] & bm, exp_wd[f]);
        end
        check(got == 0, "R6 store returns zero", 512'(got), 512'(0));
      end else begin
        check(got == exp_ld, "R5 load data", 512'(got), 512'(exp_ld));
      end
    end
    check(xl_cnt == (pc ? 1 : 0), pc ? "R4 one translation" : "R3 no translation",
          512'(xl_cnt), 512'(pc ? 1 : 0));
    if (pc)
      check(xl_vpn == va[31:12] + 20'd1, "R4 next page number", 512'(xl_vpn),
            512'(va[31:12] + 20'd1));
  endtask

  function automatic bit got_err();
    return rsp_error;
  endfunction

  initial begin
    logic [25:0] bases [3];
    bases[0] = {20'h00123, 6'd5};
    bases[1] = {20'h00123, 6'd63};
    bases[2] = {20'h00776, 6'd63};
    #3 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !cache_req_valid && !xlat_req_valid,
          "R8 reset idle state", 512'({req_ready, rsp_valid, cache_req_valid, xlat_req_valid}),
          512'(4'b1000));
    for (int bi = 0; bi < 3; bi++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 64; off++)
          for (int st = 0; st < 2; st++)
            run_access(st[0], sz, {bases[bi], 6'(off)});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end
endmodule